// File: doc/BRIEF.md
# Tick Match Timer

This block is a free-running tick counter with a set of compare slots that share one interrupt line. A strobe input, synchronous to the system clock and pulsing at 32768 Hz, advances the count by one. Software reaches the block through a single-cycle register port with a write strobe, a byte address, write data and combinational read data. Through that port it can start and stop the count, load a new value, read the live value, program the compare slots and acknowledge interrupts.

The count runs only while two control bits, a run bit and an oscillator-good bit, are both set. While it is stopped, the count holds its value and reads back as zero, and loads and compare writes are dropped. Each compare slot fires once, when an increment brings the count onto its stored value. A fired slot sets a sticky status bit that drives the level interrupt, and the slot then stays quiet until it is rewritten or the count is re-enabled. Stopping the count cancels every armed slot. Starting it again arms all of them from their stored values.

Register map (byte offsets): 0x00 control, with bit 0 run and bit 1 oscillator-good. 0x04 count load, write only. 0x08 count read. 0x0C + 4*i compare slot i. 0x20 status, where bit i belongs to slot i, a read returns the bits and writing 1 clears a bit.

Top module: `tick_match_timer`

## Requirements
- R1: After reset, control, every compare slot and the status register read 0, the count reads 0 and irq is low.
- R2: The count is enabled only when control bit 0 and bit 1 are both 1. While enabled, it advances by exactly one on each clock with tick_stb high. While not enabled, it holds its value.
- R3: A read at 0x08 returns 0 while the count is not enabled and the live count while it is enabled.
- R4: A write to 0x04 while enabled loads the count with the write data, and this takes precedence over a tick in the same cycle. The same write while not enabled is ignored.
- R5: The count wraps from 0xFFFFFFFF to 0 on a tick.
- R6: A write to a compare slot is stored only while enabled and is ignored otherwise. Slot contents read back regardless of enable.
- R7: When a tick moves the count onto the value of an armed slot i, status bit i is set at that same clock edge and irq goes high. Loading the count to a slot's value does not set the bit.
- R8: A slot disarms when it fires and does not fire again until it is rewritten or the count goes from disabled to enabled.
- R9: A control write that disables the count disarms every slot. A control write that enables it arms every slot.
- R10: Writing 1 to status bit i clears it. If slot i fires in the same cycle as the clear, the set wins. irq is high exactly while any status bit is set.
- R11: A read of any unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_stb | input | 1 | 32768 Hz count strobe, one clock wide |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Level interrupt, high while any status bit is set |

## Verification
Two collisions are provoked on purpose. In the first, a tick and a count load fall in the same cycle, and the bench judges the result by reading back exactly the loaded value, not that value plus one. In the second, a slot-matching tick coincides with a status-clear write to the same bit, and the bench judges it by the status bit and irq both remaining set afterwards. The wrap from the top value onto a slot holding zero is also driven, and the bench expects both the rolled-over count and that slot's status bit.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
   localparam int OFF_CTRL     = 'h00;
   localparam int OFF_LOAD     = 'h04;
   localparam int OFF_COUNT    = 'h08;
   localparam int OFF_CMP_BASE = 'h0C;
   localparam int OFF_STATUS   = 'h20;
   localparam int MAX_SLOTS    = (OFF_STATUS - OFF_CMP_BASE) / 4;

   localparam int CTRL_RUN_BIT = 0;
   localparam int CTRL_OSC_BIT = 1;

   function automatic int slot_offset(input int idx);
      return OFF_CMP_BASE + 4 * idx;
   endfunction
endpackage

// File: rtl/tcm_ctrl.sv
module tcm_ctrl
   import tcm_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [DATA_W-1:0] wdata,
   output logic              run_q,
   output logic              osc_q,
   output logic              en,
   output logic              en_rise,
   output logic              en_fall
);
   logic new_en;

   assign en     = run_q & osc_q;
   assign new_en = wdata[CTRL_RUN_BIT] & wdata[CTRL_OSC_BIT];

   always_comb begin
      en_rise = ctrl_we & ~en & new_en;
      en_fall = ctrl_we & en & ~new_en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         osc_q <= 1'b0;
      end else if (ctrl_we) begin
         run_q <= wdata[CTRL_RUN_BIT];
         osc_q <= wdata[CTRL_OSC_BIT];
      end
   end
endmodule

// File: rtl/tcm_counter.sv
module tcm_counter #(
   parameter int CNT_W  = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              tick_stb,
   input  logic              load_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [CNT_W-1:0]  cnt_q,
   output logic [CNT_W-1:0]  cnt_inc,
   output logic              step
);
   assign cnt_inc = cnt_q + CNT_W'(1);

   always_comb begin
      step = en & tick_stb & ~load_we;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_we) begin
         cnt_q <= wdata[CNT_W-1:0];
      end else if (step) begin
         cnt_q <= cnt_inc;
      end
   end
endmodule

// File: rtl/tcm_slot.sv
module tcm_slot #(
   parameter int CNT_W  = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_we,
   input  logic [DATA_W-1:0] wdata,
   input  logic              step,
   input  logic [CNT_W-1:0]  cnt_inc,
   input  logic              en_rise,
   input  logic              en_fall,
   input  logic              stat_clr,
   output logic [CNT_W-1:0]  cmp_q,
   output logic              armed_q,
   output logic              status_q
);
   logic hit;

   always_comb begin
      hit = step & armed_q & (cnt_inc == cmp_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '0;
      end else if (cmp_we) begin
         cmp_q <= wdata[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (en_fall) begin
         armed_q <= 1'b0;
      end else if (en_rise || cmp_we) begin
         armed_q <= 1'b1;
      end else if (hit) begin
         armed_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= 1'b0;
      end else if (hit) begin
         status_q <= 1'b1;
      end else if (stat_clr) begin
         status_q <= 1'b0;
      end
   end
endmodule

// File: rtl/tick_match_timer.sv
module tick_match_timer
   import tcm_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 32,
   parameter int NUM_SLOTS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_stb,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   localparam int ST_W = NUM_SLOTS;

   generate
      if (NUM_SLOTS < 1 || NUM_SLOTS > MAX_SLOTS) begin : g_bad_slots
         $error("NUM_SLOTS out of range");
      end
      if (CNT_W > DATA_W || CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be between 2 and DATA_W");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("ADDR_W too narrow for the register map");
      end
   endgenerate

   logic run_q, osc_q, en, en_rise, en_fall;
   logic ctrl_we, load_we, stat_we;
   logic [NUM_SLOTS-1:0] cmp_we;
   logic [CNT_W-1:0] cnt_q, cnt_inc;
   logic step;
   logic [NUM_SLOTS-1:0][CNT_W-1:0] cmp_q;
   logic [ST_W-1:0] armed_q, status_q;

   always_comb begin
      ctrl_we = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
      load_we = bus_we && en && (bus_addr == ADDR_W'(OFF_LOAD));
      stat_we = bus_we && (bus_addr == ADDR_W'(OFF_STATUS));
      for (int i = 0; i < NUM_SLOTS; i++) begin
         cmp_we[i] = bus_we && en && (bus_addr == ADDR_W'(slot_offset(i)));
      end
   end

   tcm_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .wdata(bus_wdata),
      .run_q(run_q), .osc_q(osc_q), .en(en), .en_rise(en_rise), .en_fall(en_fall)
   );

   tcm_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(en), .tick_stb(tick_stb), .load_we(load_we),
      .wdata(bus_wdata), .cnt_q(cnt_q), .cnt_inc(cnt_inc), .step(step)
   );

   generate
      for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
         tcm_slot #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .cmp_we(cmp_we[g]), .wdata(bus_wdata),
            .step(step), .cnt_inc(cnt_inc), .en_rise(en_rise), .en_fall(en_fall),
            .stat_clr(stat_we & bus_wdata[g]),
            .cmp_q(cmp_q[g]), .armed_q(armed_q[g]), .status_q(status_q[g])
         );
      end
   endgenerate

   assign irq = |status_q;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFF_CTRL)) begin
         bus_rdata[CTRL_RUN_BIT] = run_q;
         bus_rdata[CTRL_OSC_BIT] = osc_q;
      end else if (bus_addr == ADDR_W'(OFF_COUNT)) begin
         bus_rdata = en ? DATA_W'(cnt_q) : '0;
      end else if (bus_addr == ADDR_W'(OFF_STATUS)) begin
         bus_rdata = DATA_W'(status_q);
      end else begin
         for (int i = 0; i < NUM_SLOTS; i++) begin
            if (bus_addr == ADDR_W'(slot_offset(i))) begin
               bus_rdata = DATA_W'(cmp_q[i]);
            end
         end
      end
   end
endmodule

// File: rtl/tick_match_timer_chk.sv
module tick_match_timer_chk
   import tcm_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 32,
   parameter int NUM_SLOTS = 3
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            en,
   input logic                            tick_stb,
   input logic                            load_we,
   input logic [DATA_W-1:0]               bus_wdata,
   input logic [ADDR_W-1:0]               bus_addr,
   input logic [DATA_W-1:0]               bus_rdata,
   input logic [CNT_W-1:0]                cnt_q,
   input logic [NUM_SLOTS-1:0][CNT_W-1:0] cmp_q,
   input logic [NUM_SLOTS-1:0]            armed_q,
   input logic                            irq
);
   // R2: a stopped count does not move
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> cnt_q == $past(cnt_q));

   // R2: one step per enabled tick
   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick_stb && !load_we) |=> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)));

   // R4: load lands exactly
   a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
      load_we |=> cnt_q == $past(bus_wdata[CNT_W-1:0]));

   // R3: stopped count reads zero
   a_r3_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && bus_addr == ADDR_W'(OFF_COUNT)) |-> bus_rdata == '0);

   // R6: slots frozen while stopped
   a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> cmp_q == $past(cmp_q));

   // R9: disabling leaves nothing armed
   a_r9_disarm: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en) |-> armed_q == '0);

   // R9: enabling arms everything
   a_r9_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en) |-> &armed_q);

   // R7: interrupt only rises after a tick
   a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(tick_stb));
endmodule

bind tick_match_timer tick_match_timer_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .NUM_SLOTS(NUM_SLOTS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .tick_stb(tick_stb), .load_we(load_we),
   .bus_wdata(bus_wdata), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
   .cnt_q(cnt_q), .cmp_q(cmp_q), .armed_q(armed_q), .irq(irq)
);

// File: tb/tick_match_timer_test.sv
module tick_match_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_stb = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int n_total = 0;
   int n_pass  = 0;
   bit done = 0;

   localparam logic [7:0] A_CTRL = 8'h00, A_LOAD = 8'h04, A_CNT = 8'h08,
                          A_C0 = 8'h0C, A_C1 = 8'h10, A_C2 = 8'h14, A_ST = 8'h20;

   always #4 clk = ~clk;

   tick_match_timer uut (
      .clk(clk), .rst_n(rst_n), .tick_stb(tick_stb), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_total++;
      if (got === exp) n_pass++;
      else $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_stb = 1'b1;
         @(negedge clk); tick_stb = 1'b0;
      end
   endtask

   task automatic tick_with_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      tick_stb = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      tick_stb = 1'b0; bus_we = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(A_CTRL, v); check("R1 ctrl", v, 0);
      rd(A_C0, v); check("R1 cmp0", v, 0);
      rd(A_C2, v); check("R1 cmp2", v, 0);
      rd(A_ST, v); check("R1 status", v, 0);
      rd(A_CNT, v); check("R1 count", v, 0);
      check("R1 irq", {31'b0, irq}, 0);
   endtask

   task automatic t_gating;
      logic [31:0] v;
      wr(A_CTRL, 32'h1);
      ticks(3);
      rd(A_CNT, v); check("R3 read zero when osc bit clear", v, 0);
      wr(A_CTRL, 32'h3);
      rd(A_CNT, v); check("R2 no count with one bit", v, 0);
      ticks(4);
      rd(A_CNT, v); check("R2 counts ticks", v, 4);
      wr(A_CTRL, 32'h2);
      ticks(3);
      rd(A_CNT, v); check("R3 zero while stopped", v, 0);
      wr(A_LOAD, 32'd99);
      wr(A_CTRL, 32'h3);
      rd(A_CNT, v); check("R2 R4 held, load ignored", v, 4);
      rd(A_CTRL, v); check("R2 ctrl readback", v, 3);
   endtask

   task automatic t_load_vs_tick;
      logic [31:0] v;
      tick_with_write(A_LOAD, 32'd500);
      rd(A_CNT, v); check("R4 load beats tick", v, 500);
   endtask

   task automatic t_compare;
      logic [31:0] v;
      wr(A_C1, 32'd1010);
      rd(A_C1, v); check("R6 cmp stored", v, 1010);
      wr(A_LOAD, 32'd1000);
      ticks(9);
      rd(A_ST, v); check("R7 no early match", v, 0);
      ticks(1);
      rd(A_ST, v); check("R7 match sets bit1", v, 2);
      check("R10 irq high", {31'b0, irq}, 1);
      wr(A_ST, 32'h2);
      rd(A_ST, v); check("R10 status cleared", v, 0);
      check("R10 irq low", {31'b0, irq}, 0);
   endtask

   task automatic t_load_equal;
      logic [31:0] v;
      wr(A_C0, 32'd2000);
      wr(A_LOAD, 32'd2000);
      ticks(1);
      rd(A_ST, v); check("R7 load onto compare does not fire", v, 0);
   endtask

   task automatic t_one_shot;
      logic [31:0] v;
      wr(A_LOAD, 32'd1005);
      ticks(5);
      rd(A_ST, v); check("R8 disarmed after firing", v, 0);
      wr(A_CTRL, 32'h0);
      wr(A_CTRL, 32'h3);
      wr(A_LOAD, 32'd1005);
      ticks(5);
      rd(A_ST, v); check("R9 re-enable rearms", v, 2);
      wr(A_ST, 32'h2);
      wr(A_C1, 32'd1010);
      wr(A_LOAD, 32'd1005);
      ticks(5);
      rd(A_ST, v); check("R8 rewrite rearms", v, 2);
      wr(A_ST, 32'h2);
   endtask

   task automatic t_race;
      logic [31:0] v;
      wr(A_C0, 32'd4000);
      wr(A_LOAD, 32'd3999);
      tick_with_write(A_ST, 32'h1);
      rd(A_ST, v); check("R10 set wins over clear", v, 1);
      check("R10 irq stays high", {31'b0, irq}, 1);
      wr(A_ST, 32'h1);
      check("R10 irq low after clear", {31'b0, irq}, 0);
   endtask

   task automatic t_wrap;
      logic [31:0] v;
      wr(A_LOAD, 32'hFFFF_FFFF);
      ticks(1);
      rd(A_CNT, v); check("R5 wrap to zero", v, 0);
      rd(A_ST, v); check("R5 R7 wrap hits slot at zero", v, 4);
      wr(A_ST, 32'h4);
   endtask

   task automatic t_cmp_ignore;
      logic [31:0] v;
      wr(A_CTRL, 32'h1);
      wr(A_C2, 32'd77);
      rd(A_C2, v); check("R6 write ignored while stopped", v, 0);
      rd(A_C0, v); check("R6 readable while stopped", v, 4000);
   endtask

   task automatic t_unmapped;
      logic [31:0] v;
      rd(8'h3C, v); check("R11 unmapped 0x3C", v, 0);
      rd(8'h18, v); check("R11 unmapped 0x18", v, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_total++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         $display("%0d/%0d checks passed", n_pass, n_total);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_gating;
      t_load_vs_tick;
      t_compare;
      t_load_equal;
      t_one_shot;
      t_race;
      t_wrap;
      t_cmp_ignore;
      t_unmapped;
      done = 1;
      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
   end
endmodule